// File: doc/BRIEF.md
# Per-Bit Selectable Parallel I/O Port

This block drives a bank of bidirectional I/O lines, 32 by default. Each line has its own ownership choice. It either follows a host-written output value and direction, or it is handed whole to an internal protocol engine that supplies its own value and enable. The block generates the per-line output value and output enable for the pad ring. It also returns the level seen on every pad, so the host can watch both the lines it listens to and the lines being driven.

The host reaches the block through a small synchronous register port. There is a write strobe, a two-bit address, write data and combinational read data. There are three writable registers and one read-only pin view:

| Address | Register |
|---------|----------|
| 0 | Output value |
| 1 | Direction |
| 2 | Ownership select |
| 3 | Pin view (read-only) |

The pin view passes through a two-flop synchronizer and applies no filtering. When the pad loops its own drive back, a driven line reads back its transmitted value.

Top module: `pio_mux_port`

## Requirements
- R1: After reset, the output value, direction and ownership select registers all read 0, and every output enable is 0. All lines therefore start as host-owned receivers.
- R2: A write with `wr_en` high to address 0, 1 or 2 loads `wdata` into that register at the clock edge. A read of the same address returns the new value from that edge onward.
- R3: A line whose select bit is 0 and whose direction bit is 1 drives `pin_oe` high and `pin_out` equal to its output value bit.
- R4: A line whose select bit is 0 and whose direction bit is 0 holds `pin_oe` low.
- R5: A line whose select bit is 1 takes `pin_out` from `sm_out` and `pin_oe` from `sm_oe`, whatever its direction and output value bits hold.
- R6: Reading address 3 returns `pin_in` as it stood two clock edges earlier, with no filtering.
- R7: With the pad feeding its own drive back, a driven line (from either owner) reads back at address 3 the value it transmits.
- R8: A write to address 3 changes no register.
- R9: With `wr_en` low, no register changes, whatever the address and data inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 value, 1 direction, 2 select, 3 pin view) |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data for `addr`, combinational |
| sm_out | input | WIDTH | Protocol engine output values |
| sm_oe | input | WIDTH | Protocol engine output enables |
| pin_in | input | WIDTH | Levels sampled at the pads |
| pin_out | output | WIDTH | Values driven toward the pads |
| pin_oe | output | WIDTH | Per-line output enables |

## Verification
Register contents, `pin_out` and `pin_oe` settle in the same cycle as the write edge. The bench therefore checks them a short delay after that edge, once the write task has returned. The pin view trails the pads by exactly two edges. The bench waits two edges after the last change to the pads before comparing. A directed case samples after one edge to confirm the old level is still shown, then after the second edge to see the new one. All inputs change just after a rising edge, so no sample coincides with a clock edge.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      PIO_VAL  = 2'd0,
      PIO_DIR  = 2'd1,
      PIO_SEL  = 2'd2,
      PIO_PINS = 2'd3
   } pio_addr_e;
endpackage

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] val_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] sel_q
);
   logic hit_val, hit_dir, hit_sel;

   always_comb begin
      hit_val = wr_en && (addr == PIO_VAL);
      hit_dir = wr_en && (addr == PIO_DIR);
      hit_sel = wr_en && (addr == PIO_SEL);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         val_q <= '0;
         dir_q <= '0;
         sel_q <= '0;
      end else begin
         if (hit_val) val_q <= wdata;
         if (hit_dir) dir_q <= wdata;
         if (hit_sel) sel_q <= wdata;
      end
   end

   // R1: every register is clear once reset has been applied
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (val_q == '0 && dir_q == '0 && sel_q == '0));

   // R2: a write to the direction register lands on the next edge
   p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == PIO_DIR) |=> (dir_q == $past(wdata)));

   // R9: without a strobe the registers hold
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> ($stable(val_q) && $stable(dir_q) && $stable(sel_q)));

   // R8: a write to the pin view leaves the registers alone
   p_pins_ro_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == PIO_PINS) |=> ($stable(val_q) && $stable(dir_q) && $stable(sel_q)));
endmodule

// File: rtl/pio_bit_sel.sv
module pio_bit_sel #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] val_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] sel_q,
   input  logic [WIDTH-1:0] sm_out,
   input  logic [WIDTH-1:0] sm_oe,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      always_comb begin
         if (sel_q[i]) begin
            pin_out[i] = sm_out[i];
            pin_oe[i]  = sm_oe[i];
         end else begin
            pin_out[i] = val_q[i];
            pin_oe[i]  = dir_q[i];
         end
      end
   end
endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[s] <= '0;
         else     chain[s] <= chain[s-1];
      end
      // R6: each stage carries the previous one a cycle later
      p_chain_step_r6: assert property (@(posedge clk) disable iff (rst)
         1'b1 |=> (chain[s] == $past(chain[s-1])));
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pio_mux_port.sv
module pio_mux_port
   import pio_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   input  logic [WIDTH-1:0] sm_out,
   input  logic [WIDTH-1:0] sm_oe,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe
);
   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("pio_mux_port: WIDTH must lie in 1..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_mux_port: SYNC_STAGES must be at least 2");
   end

   logic [WIDTH-1:0] val_q, dir_q, sel_q, pins_s;

   pio_regs #(.WIDTH(WIDTH)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .val_q(val_q), .dir_q(dir_q), .sel_q(sel_q)
   );

   pio_bit_sel #(.WIDTH(WIDTH)) u_sel (
      .val_q(val_q), .dir_q(dir_q), .sel_q(sel_q),
      .sm_out(sm_out), .sm_oe(sm_oe),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pin_in), .q(pins_s)
   );

   always_comb begin
      unique case (addr)
         PIO_VAL:  rdata = val_q;
         PIO_DIR:  rdata = dir_q;
         PIO_SEL:  rdata = sel_q;
         default:  rdata = pins_s;
      endcase
   end

   // R4: host-owned receivers never drive
   p_recv_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      ((~sel_q & ~dir_q & pin_oe) == '0));

   // R3: host-owned transmitters carry the value register
   p_host_drive_r3: assert property (@(posedge clk) disable iff (rst)
      (((~sel_q & dir_q) & ~pin_oe) == '0) &&
      (((~sel_q & dir_q) & (pin_out ^ val_q)) == '0));

   // R5: engine-owned lines follow the engine
   p_engine_owns_r5: assert property (@(posedge clk) disable iff (rst)
      ((sel_q & (pin_oe ^ sm_oe)) == '0) && ((sel_q & (pin_out ^ sm_out)) == '0));
endmodule

// File: tb/pio_mux_port_test.sv
module pio_mux_port_test;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst;
   logic         wr_en;
   logic [1:0]   addr;
   logic [W-1:0] wdata, rdata, sm_out, sm_oe, pin_in, pin_out, pin_oe, ext;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   // pad model: a driven line shows its drive, otherwise the far end
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

   pio_mux_port #(.WIDTH(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .sm_out(sm_out), .sm_oe(sm_oe), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   function automatic logic [W-1:0] exp_oe(input logic [W-1:0] d, s, so);
      return (s & so) | (~s & d);
   endfunction

   function automatic logic [W-1:0] exp_out(input logic [W-1:0] v, s, sv);
      return (s & sv) | (~s & v);
   endfunction

   function automatic logic [W-1:0] exp_pad(input logic [W-1:0] oe, o, e);
      return (oe & o) | (~oe & e);
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, d, s, r;
      void'($urandom(32'h5eed1234));
      rst = 1'b1; wr_en = 1'b0; addr = 2'd0; wdata = '0;
      sm_out = '0; sm_oe = '0; ext = '0;
      repeat (3) tick();
      rst = 1'b0;
      tick();

      // R1: reset state
      rd(2'd0, r); check("R1 value reg", r, '0);
      rd(2'd1, r); check("R1 dir reg", r, '0);
      rd(2'd2, r); check("R1 sel reg", r, '0);
      check("R1 oe", pin_oe, '0);

      // directed: all lines host-owned transmitters
      sm_out = $urandom(); sm_oe = $urandom();
      wr(2'd0, 32'hA5C3_0F96);
      wr(2'd1, '1);
      check("R3 all transmit oe", pin_oe, '1);
      check("R3 all transmit out", pin_out, 32'hA5C3_0F96);
      // directed: all lines engine-owned
      wr(2'd2, '1);
      check("R5 all engine oe", pin_oe, sm_oe);
      check("R5 all engine out", pin_out, sm_out);

      // random mixes
      for (int i = 0; i < 40; i++) begin
         v = $urandom(); d = $urandom(); s = $urandom();
         sm_out = $urandom(); sm_oe = $urandom(); ext = $urandom();
         wr(2'd0, v); wr(2'd1, d); wr(2'd2, s);
         rd(2'd0, r); check("R2 value reg", r, v);
         rd(2'd1, r); check("R2 dir reg", r, d);
         rd(2'd2, r); check("R2 sel reg", r, s);
         check("R3 R4 R5 oe", pin_oe, exp_oe(d, s, sm_oe));
         check("R3 R5 out", pin_out, exp_out(v, s, sm_out));
         check("R4 receivers quiet", pin_oe & ~s & ~d, '0);
         tick(); tick();
         rd(2'd3, r);
         check("R7 pin view", r, exp_pad(exp_oe(d, s, sm_oe), exp_out(v, s, sm_out), ext));
      end

      // R6: exact two-edge lag on receivers
      wr(2'd2, '0); wr(2'd1, '0);
      ext = 32'h1234_5678;
      tick(); tick();
      ext = 32'hFEDC_BA98;
      tick();
      rd(2'd3, r); check("R6 one edge old", r, 32'h1234_5678);
      tick();
      rd(2'd3, r); check("R6 two edges new", r, 32'hFEDC_BA98);

      // R8: write to pin view
      wr(2'd0, 32'h0000_FFFF); wr(2'd1, 32'h00FF_00FF); wr(2'd2, 32'h0F0F_0F0F);
      wr(2'd3, 32'hDEAD_BEEF);
      rd(2'd0, r); check("R8 value kept", r, 32'h0000_FFFF);
      rd(2'd1, r); check("R8 dir kept", r, 32'h00FF_00FF);
      rd(2'd2, r); check("R8 sel kept", r, 32'h0F0F_0F0F);

      // R9: no strobe
      for (int a = 0; a < 3; a++) begin
         wr_en = 1'b0; addr = 2'(a); wdata = 32'hCAFE_F00D;
         tick();
      end
      rd(2'd0, r); check("R9 value kept", r, 32'h0000_FFFF);
      rd(2'd1, r); check("R9 dir kept", r, 32'h00FF_00FF);
      rd(2'd2, r); check("R9 sel kept", r, 32'h0F0F_0F0F);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule